// File: doc/BRIEF.md
# Microcontroller Standby Mode Controller

This block governs the low-power modes of a small microcontroller. Software configures it through two byte-wide registers that share one write port: a control register, and a code register that must receive a two-byte unlock sequence before a stop request is honoured. From the register contents and a few strobes, the controller drives the clock enable for the CPU core and the clock enable for the peripherals. It also drives the main-oscillator enable and a request to put the output pins into high impedance.

There are two standby modes. In the light mode only the CPU clock is stopped, so timers and serial ports keep running. In the deep mode both clocks are stopped, and the oscillator can also be switched off. Each mode is entered at the next instruction boundary after the request bit is written. When the block wakes, it pulses a one-cycle notice that tells the CPU to do one of three things: service an interrupt, continue with the next instruction, or run reset processing. If the oscillator was switched off, the notice is held back until a stabilization delay has run. Interrupt sources, the watchdog and the reset pin reach the block as plain level inputs.

Top module: `standby_ctrl`

## Requirements
- R1: After `rst`, `mode` is 0 (run), `rd_data` is 0, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `port_float` is 0. The control register has this layout: bit 0 deep-mode request, bit 1 light-mode request, bit 2 pin float, bit 3 oscillator off, bits 5:4 delay select. Bits 7:6 always read 0. `wr_sel`=0 addresses the control register and `wr_sel`=1 addresses the code register.
- R2: The deep-mode request bit can be set only after two consecutive code-register writes whose low nibbles are 5h and then Ah. The high nibbles may hold any value.
- R3: In each of these cases a write of 1 to bit 0 leaves bit 0 at 0 while the other bits are stored: no unlock sequence was written; a control write came between the two code writes; a wrong value was written. A deep-mode request that is accepted uses up the unlock, so a later request needs a new sequence.
- R4: With bit 1 set, the next `insn_boundary` pulse enters light mode (`mode`=1). There `cpu_clk_en`=0, while `per_clk_en`=1 and `osc_en`=1. Nothing changes before that pulse.
- R5: In a standby mode, `nmi_req` wakes the block unconditionally, and the notice carries action 1 (service interrupt).
- R6: A maskable request wakes the block only when `irq_flag` and `irq_en` are both 1. The action is 1 if `mie`=1 and 2 (next instruction) if `mie`=0. A request without its enable leaves the mode unchanged.
- R7: In deep mode (`mode`=2), both clock enables are 0 and `osc_en` equals the inverse of bit 3. `port_float` equals bit 2 in deep mode and is 0 in every other mode.
- R8: If deep mode is woken with bit 3 at 0, the block returns straight to run. If bit 3 is 1, it spends exactly 2^(STAB_BASE+STAB_STEP*sel) cycles in `mode`=3 with `osc_en`=1 and the clocks off, where sel is bits 5:4. The notice then appears together with the return to run.
- R9: Bits 0 and 1 clear on wake-up. The other bits keep their values.
- R10: `ext_reset` or `wdt_ovf`, in any mode, forces run mode on the next cycle, clears the control register, and pulses `wake_valid` with action 3 (reset).
- R11: Register writes outside run mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = code register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control register contents |
| insn_boundary | input | 1 | Instruction boundary strobe from the CPU |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_flag | input | 1 | Maskable interrupt request flag |
| irq_en | input | 1 | Enable flag of that interrupt |
| mie | input | 1 | Master interrupt enable |
| ext_reset | input | 1 | Reset pin request |
| wdt_ovf | input | 1 | Watchdog overflow |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| port_float | output | 1 | Output pins to high impedance |
| mode | output | 2 | 0 run, 1 light standby, 2 deep standby, 3 stabilizing |
| wake_valid | output | 1 | One-cycle wake/reset notice |
| wake_action | output | 2 | 1 service interrupt, 2 next instruction, 3 reset |

## Verification
The bench builds the block with STAB_BASE=2 and STAB_STEP=1, which gives delays of 4, 8, 16 and 32 cycles in place of the default 256 to 16384. With these values all four delay selects can be run and their exact cycle counts compared, and the rest of the scenarios still fit in a short run. The default build keeps the same structure, with a wider down-counter.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HALT = 2'd1,
        MODE_STOP = 2'd2,
        MODE_STAB = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        WAKE_NONE      = 2'd0,
        WAKE_TAKE_INT  = 2'd1,
        WAKE_NEXT_INSN = 2'd2,
        WAKE_RESET     = 2'd3
    } wake_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_ARMED = 2'd2
    } acc_e;

    // control register, packed so that bit 0 is the deep-mode request
    typedef struct packed {
        logic [1:0] dly_sel;
        logic       osc_off;
        logic       pin_flt;
        logic       halt_req;
        logic       stop_req;
    } sby_ctrl_t;

    localparam logic [3:0] CODE_FIRST  = 4'h5;
    localparam logic [3:0] CODE_SECOND = 4'hA;

    function automatic int unsigned stab_shift(input logic [1:0] sel,
                                               input int unsigned base,
                                               input int unsigned step);
        return base + step * int'(sel);
    endfunction

endpackage

// File: rtl/stby_code_acceptor.sv
module stby_code_acceptor
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       acc_wr,
    input  logic       other_wr,
    input  logic [3:0] nib,
    input  logic       consume,
    output logic       armed
);
    acc_e st_q;

    always_ff @(posedge clk) begin
        if (rst || clr || consume) begin
            st_q <= ACC_IDLE;
        end else if (acc_wr) begin
            if (nib == CODE_FIRST)
                st_q <= ACC_HALF;
            else if (nib == CODE_SECOND && st_q == ACC_HALF)
                st_q <= ACC_ARMED;
            else
                st_q <= ACC_IDLE;
        end else if (other_wr && st_q == ACC_HALF) begin
            st_q <= ACC_IDLE;
        end
    end

    assign armed = (st_q == ACC_ARMED);
endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer
    import stby_pkg::*;
#(
    parameter int unsigned STAB_BASE = 8,
    parameter int unsigned STAB_STEP = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       start,
    input  logic [1:0] sel,
    output logic       done
);
    localparam int unsigned MAX_SHIFT = STAB_BASE + 3 * STAB_STEP;
    localparam int unsigned CNT_W     = MAX_SHIFT + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             busy_q;

    always_comb load_val = (CNT_W'(1) << stab_shift(sel, STAB_BASE, STAB_STEP)) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/stby_wake_qual.sv
module stby_wake_qual
    import stby_pkg::*;
(
    input  logic  nmi_req,
    input  logic  irq_flag,
    input  logic  irq_en,
    input  logic  mie,
    output logic  wake,
    output wake_e action
);
    logic mask_ok;

    always_comb begin
        mask_ok = irq_flag && irq_en;
        wake    = nmi_req || mask_ok;
        if (nmi_req || mie) action = WAKE_TAKE_INT;
        else                action = WAKE_NEXT_INSN;
    end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned STAB_BASE = 8,
    parameter int unsigned STAB_STEP = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       insn_boundary,
    input  logic       nmi_req,
    input  logic       irq_flag,
    input  logic       irq_en,
    input  logic       mie,
    input  logic       ext_reset,
    input  logic       wdt_ovf,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       port_float,
    output logic [1:0] mode,
    output logic       wake_valid,
    output logic [1:0] wake_action
);
    mode_e     mode_q;
    sby_ctrl_t ctrl_q;
    wake_e     act_q, pend_q;
    logic      wv_q;

    logic  rst_src, wr_ctrl, wr_acc, armed, stp_ok;
    logic  wake, t_start, t_done;
    wake_e wake_act;
    logic  unused_hi;

    assign unused_hi = ^wr_data[7:6];
    assign rst_src   = ext_reset || wdt_ovf;
    assign wr_ctrl   = wr_en && !wr_sel && (mode_q == MODE_RUN);
    assign wr_acc    = wr_en &&  wr_sel && (mode_q == MODE_RUN);
    assign stp_ok    = wr_ctrl && wr_data[0] && armed;
    assign t_start   = (mode_q == MODE_STOP) && wake && ctrl_q.osc_off && !rst_src;

    stby_code_acceptor u_acc (
        .clk      (clk),
        .rst      (rst),
        .clr      (rst_src),
        .acc_wr   (wr_acc),
        .other_wr (wr_ctrl),
        .nib      (wr_data[3:0]),
        .consume  (stp_ok),
        .armed    (armed)
    );

    stby_stab_timer #(
        .STAB_BASE (STAB_BASE),
        .STAB_STEP (STAB_STEP)
    ) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (rst_src),
        .start (t_start),
        .sel   (ctrl_q.dly_sel),
        .done  (t_done)
    );

    stby_wake_qual u_wq (
        .nmi_req  (nmi_req),
        .irq_flag (irq_flag),
        .irq_en   (irq_en),
        .mie      (mie),
        .wake     (wake),
        .action   (wake_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RUN;
            ctrl_q <= '0;
            act_q  <= WAKE_NONE;
            pend_q <= WAKE_NONE;
            wv_q   <= 1'b0;
        end else if (rst_src) begin
            mode_q <= MODE_RUN;
            ctrl_q <= '0;
            act_q  <= WAKE_RESET;
            pend_q <= WAKE_NONE;
            wv_q   <= 1'b1;
        end else begin
            wv_q <= 1'b0;
            unique case (mode_q)
                MODE_RUN: begin
                    if (wr_ctrl) begin
                        ctrl_q.dly_sel  <= wr_data[5:4];
                        ctrl_q.osc_off  <= wr_data[3];
                        ctrl_q.pin_flt  <= wr_data[2];
                        ctrl_q.halt_req <= wr_data[1];
                        ctrl_q.stop_req <= stp_ok || (ctrl_q.stop_req && wr_data[0]);
                    end
                    if (insn_boundary) begin
                        if (ctrl_q.stop_req)      mode_q <= MODE_STOP;
                        else if (ctrl_q.halt_req) mode_q <= MODE_HALT;
                    end
                end
                MODE_HALT: begin
                    if (wake) begin
                        mode_q          <= MODE_RUN;
                        ctrl_q.halt_req <= 1'b0;
                        ctrl_q.stop_req <= 1'b0;
                        act_q           <= wake_act;
                        wv_q            <= 1'b1;
                    end
                end
                MODE_STOP: begin
                    if (wake) begin
                        ctrl_q.halt_req <= 1'b0;
                        ctrl_q.stop_req <= 1'b0;
                        if (ctrl_q.osc_off) begin
                            mode_q <= MODE_STAB;
                            pend_q <= wake_act;
                        end else begin
                            mode_q <= MODE_RUN;
                            act_q  <= wake_act;
                            wv_q   <= 1'b1;
                        end
                    end
                end
                MODE_STAB: begin
                    if (t_done) begin
                        mode_q <= MODE_RUN;
                        act_q  <= pend_q;
                        wv_q   <= 1'b1;
                    end
                end
                default: mode_q <= MODE_RUN;
            endcase
        end
    end

    assign cpu_clk_en  = (mode_q == MODE_RUN);
    assign per_clk_en  = (mode_q == MODE_RUN) || (mode_q == MODE_HALT);
    assign osc_en      = !((mode_q == MODE_STOP) && ctrl_q.osc_off);
    assign port_float  = (mode_q == MODE_STOP) && ctrl_q.pin_flt;
    assign mode        = mode_q;
    assign rd_data     = {2'b00, ctrl_q};
    assign wake_valid  = wv_q;
    assign wake_action = act_q;
endmodule

// File: rtl/stby_checker.sv
module stby_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rd_data,
    input logic       nmi_req,
    input logic       irq_flag,
    input logic       irq_en,
    input logic       mie,
    input logic       ext_reset,
    input logic       wdt_ovf,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       port_float,
    input logic [1:0] mode,
    input logic       wake_valid,
    input logic [1:0] wake_action
);
    a_r4_halt_clocks: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |-> (!cpu_clk_en && per_clk_en && osc_en));

    a_r7_stop_outputs: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |-> (!cpu_clk_en && !per_clk_en && (osc_en == !rd_data[3])));

    a_r7_float_only_stop: assert property (@(posedge clk) disable iff (rst)
        port_float |-> (mode == 2'd2));

    a_r8_stab_outputs: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |-> (osc_en && !cpu_clk_en && !per_clk_en));

    a_r8_notice_in_run: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> (mode == 2'd0 && cpu_clk_en));

    a_r5_nmi_wakes: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && nmi_req && !ext_reset && !wdt_ovf)
        |=> (wake_valid && wake_action == 2'd1 && mode == 2'd0));

    a_r6_mie_low_next: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && !nmi_req && irq_flag && irq_en && !mie && !ext_reset && !wdt_ovf)
        |=> (wake_valid && wake_action == 2'd2));

    a_r6_no_wake: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && !nmi_req && !(irq_flag && irq_en) && !ext_reset && !wdt_ovf)
        |=> (mode == 2'd1 && !wake_valid));

    a_r9_req_bits_clear: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> (rd_data[1:0] == 2'b00));

    a_r10_reset_src: assert property (@(posedge clk) disable iff (rst)
        (ext_reset || wdt_ovf)
        |=> (mode == 2'd0 && rd_data == 8'h00 && wake_valid && wake_action == 2'd3));
endmodule

bind standby_ctrl stby_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_data     (rd_data),
    .nmi_req     (nmi_req),
    .irq_flag    (irq_flag),
    .irq_en      (irq_en),
    .mie         (mie),
    .ext_reset   (ext_reset),
    .wdt_ovf     (wdt_ovf),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .port_float  (port_float),
    .mode        (mode),
    .wake_valid  (wake_valid),
    .wake_action (wake_action)
);

// File: tb/standby_ctrl_test.sv
`timescale 1ns/1ps
module standby_ctrl_test;
    localparam int unsigned TB_BASE = 2;
    localparam int unsigned TB_STEP = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, wr_sel = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       insn_boundary = 0, nmi_req = 0, irq_flag = 0, irq_en = 0, mie = 0;
    logic       ext_reset = 0, wdt_ovf = 0;
    logic       cpu_clk_en, per_clk_en, osc_en, port_float, wake_valid;
    logic [1:0] mode, wake_action;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [1:0] exp_q[$];

    always #4 clk = ~clk;

    standby_ctrl #(.STAB_BASE(TB_BASE), .STAB_STEP(TB_STEP)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .insn_boundary(insn_boundary), .nmi_req(nmi_req),
        .irq_flag(irq_flag), .irq_en(irq_en), .mie(mie), .ext_reset(ext_reset),
        .wdt_ovf(wdt_ovf), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .port_float(port_float), .mode(mode),
        .wake_valid(wake_valid), .wake_action(wake_action)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0; wr_sel = 0; wr_data = '0;
    endtask

    task automatic boundary();
        insn_boundary = 1;
        step();
        insn_boundary = 0;
    endtask

    task automatic unlock(input logic [3:0] hi1, input logic [3:0] hi2);
        write_reg(1'b1, {hi1, 4'h5});
        write_reg(1'b1, {hi2, 4'hA});
    endtask

    // monitor: each wake notice is compared with the next expected action
    always @(negedge clk) begin
        if (!rst && wake_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5/R6/R10 notice: actual %0d expected none", wake_action);
            end else begin
                automatic logic [1:0] e = exp_q.pop_front();
                if (wake_action != e) begin
                    n_fail++;
                    $display("FAIL R5/R6/R8/R10 notice action: actual %0d expected %0d", wake_action, e);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 clocks", {cpu_clk_en, per_clk_en, osc_en, port_float}, 4'b1110);

        // R1/R3 field layout, top bits read zero, stp ignored
        write_reg(1'b0, 8'hFF);
        check("R1 R3 layout", rd_data, 8'h3E);
        write_reg(1'b0, 8'h00);

        // R3 no unlock
        write_reg(1'b0, 8'h01);
        check("R3 no unlock", rd_data, 0);
        // R3 interrupted sequence
        write_reg(1'b1, 8'h35);
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h9A);
        write_reg(1'b0, 8'h01);
        check("R3 interrupted", rd_data, 0);
        // R3 wrong value
        write_reg(1'b1, 8'h45);
        write_reg(1'b1, 8'h4B);
        write_reg(1'b0, 8'h01);
        check("R3 wrong value", rd_data, 0);

        // R4 halt entry at boundary only
        write_reg(1'b0, 8'h02);
        check("R4 before boundary", mode, 0);
        boundary();
        check("R4 halt mode", mode, 1);
        check("R4 halt clocks", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);

        // R6 request without enable
        irq_flag = 1; irq_en = 0;
        step();
        check("R6 no enable", mode, 1);
        irq_flag = 0;
        // R11 write while halted
        write_reg(1'b0, 8'h3C);
        check("R11 ignored", rd_data, 8'h02);

        // R5 nmi
        exp_q.push_back(2'd1);
        nmi_req = 1;
        step();
        nmi_req = 0;
        check("R5 run after nmi", mode, 0);
        check("R9 halt bit cleared", rd_data, 0);

        // R6 mie=0 -> next instruction
        write_reg(1'b0, 8'h02);
        boundary();
        exp_q.push_back(2'd2);
        irq_flag = 1; irq_en = 1; mie = 0;
        step();
        irq_flag = 0; irq_en = 0;
        check("R6 mie0 run", mode, 0);
        // R6 mie=1 -> service
        write_reg(1'b0, 8'h02);
        boundary();
        exp_q.push_back(2'd1);
        irq_flag = 1; irq_en = 1; mie = 1;
        step();
        irq_flag = 0; irq_en = 0; mie = 0;
        check("R6 mie1 run", mode, 0);

        // R2/R7 stop with oscillator kept
        unlock(4'hF, 4'h0);
        write_reg(1'b0, 8'h05);
        check("R2 stp accepted", rd_data, 8'h05);
        boundary();
        check("R7 stop mode", mode, 2);
        check("R7 stop outputs", {cpu_clk_en, per_clk_en, osc_en, port_float}, 4'b0011);
        exp_q.push_back(2'd2);
        irq_flag = 1; irq_en = 1;
        step();
        irq_flag = 0; irq_en = 0;
        check("R8 direct run", mode, 0);
        check("R9 stp cleared", rd_data, 8'h04);
        check("R7 float off in run", port_float, 0);

        // R3 unlock consumed
        write_reg(1'b0, 8'h01);
        check("R3 consumed", rd_data[0], 0);

        // R8 stabilization for every delay select
        for (int s = 0; s < 4; s++) begin
            int n;
            unlock(4'(s), 4'h3);
            write_reg(1'b0, 8'h09 | 8'(s << 4));
            boundary();
            check("R7 osc off", {mode, osc_en, port_float}, 4'b1000);
            exp_q.push_back(2'd1);
            nmi_req = 1;
            step();
            nmi_req = 0;
            check("R8 stab osc on", {mode, osc_en, cpu_clk_en}, 4'b1110);
            n = 0;
            while (mode == 2'd3 && n < 100) begin
                n++;
                step();
            end
            check("R8 stab length", n, 1 << (TB_BASE + TB_STEP * s));
            check("R8 back to run", mode, 0);
            check("R9 keeps fields", rd_data, 8'h08 | 8'(s << 4));
        end

        // R10 reset pin from halt
        write_reg(1'b0, 8'h36);
        boundary();
        check("R10 in halt", mode, 1);
        exp_q.push_back(2'd3);
        ext_reset = 1;
        step();
        ext_reset = 0;
        check("R10 pin run", mode, 0);
        check("R10 pin cleared", rd_data, 0);
        // R10 watchdog in run
        write_reg(1'b0, 8'h34);
        exp_q.push_back(2'd3);
        wdt_ovf = 1;
        step();
        wdt_ovf = 0;
        check("R10 wdt cleared", rd_data, 0);

        step(); step();
        check("R5 R6 R10 all notices seen", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule